// File: doc/BRIEF.md
# Packed Decimal Add/Subtract Unit

This unit performs one decimal arithmetic step on a byte of packed BCD: two decimal digits per operand. It adds two operands and an incoming extend bit, subtracts a source and the extend bit from a destination, or subtracts the destination and the extend bit from zero. A chain of per-digit adders with ±6 correction produces the result. The carry or borrow out of the top digit is reported on both the extend and the carry outputs.

The zero flag is sticky across a multi-byte decimal operation. The caller feeds in the zero flag from the previous byte. The unit clears it when its own result is nonzero and otherwise passes it through unchanged, so a chain of bytes reports zero only if every byte was zero. The negative and overflow flags carry no meaning for these operations. They are driven low, and a fixed validity mask marks them as don't-care.

A start strobe captures the operands. The registered result and flags appear together with a one-cycle done pulse on the next clock, and they hold until the next start.

Top module: `bcd_addsub`

## Requirements
- R1: With op_i = 2'b00 the result is dst_i + src_i + x_i in decimal, modulo 100 for a two-digit byte.
- R2: With op_i = 2'b01 the result is dst_i - src_i - x_i in decimal, wrapped modulo 100.
- R3: With op_i[1] = 1 (codes 2'b10 and 2'b11) the result is 0 - dst_i - x_i in decimal, wrapped modulo 100, and src_i has no effect.
- R4: x_o and c_o are both 1 when the operation produced a decimal carry (add) or a decimal borrow (subtract, negate), and both are 0 otherwise.
- R5: z_o is 0 when the result is nonzero and equals z_i otherwise, so the operation never sets it.
- R6: n_o and v_o are 0 after every operation. flag_valid_o is 5'b10101, with bit order {X, N, Z, V, C}, which marks N and V as don't-care.
- R7: done_o is high for exactly the one cycle after each cycle in which start_i is high.
- R8: result_o and the flags change only in the cycle after a start and hold their values otherwise.
- R9: An asserted rst_ni clears result_o, all flags and done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture operands and operation |
| op_i | input | 2 | 00 add, 01 subtract, 1x negate |
| dst_i | input | 8 | Destination operand, packed BCD |
| src_i | input | 8 | Source operand, packed BCD |
| x_i | input | 1 | Incoming extend bit |
| z_i | input | 1 | Incoming zero flag |
| result_o | output | 8 | Registered packed BCD result |
| x_o | output | 1 | Extend flag out |
| c_o | output | 1 | Carry/borrow flag out |
| z_o | output | 1 | Sticky zero flag out |
| n_o | output | 1 | Negative flag, driven 0 |
| v_o | output | 1 | Overflow flag, driven 0 |
| flag_valid_o | output | 5 | Defined-flag mask {X,N,Z,V,C} |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with the default NUM_DIGITS = 2, a byte of two digits. With that width a decimal reference model over the range 0 to 99 can sweep a dense grid of operand pairs for every operation code and both extend values. The width also brings the wrap corners within reach: 99+99+1, 0-0-1, and negation of zero with and without extend. Back-to-back starts exercise the one-cycle done timing, and idle gaps exercise the hold behaviour.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_NEG  = 2'b10,
    OP_NEG2 = 2'b11
  } bcd_op_e;

  localparam int unsigned FLAG_W = 5;
  // bit order {X, N, Z, V, C}
  localparam logic [FLAG_W-1:0] FLAG_VALID = 5'b10101;
endpackage

// File: rtl/bcd_digit.sv
module bcd_digit (
  input  logic       sub_i,
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cin_i,
  output logic [3:0] dig_o,
  output logic       cout_o
);
  logic [4:0] raw;
  logic       adj;

  always_comb begin
    if (sub_i) raw = {1'b0, a_i} - {1'b0, b_i} - {4'd0, cin_i};
    else       raw = {1'b0, a_i} + {1'b0, b_i} + {4'd0, cin_i};
    // add: fix when binary sum leaves decimal range; sub: fix on nibble borrow
    adj = sub_i ? raw[4] : (raw > 5'd9);
    if (!adj)       dig_o = raw[3:0];
    else if (sub_i) dig_o = raw[3:0] - 4'd6;
    else            dig_o = raw[3:0] + 4'd6;
    cout_o = adj;
  end
endmodule

// File: rtl/bcd_flags.sv
module bcd_flags #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         carry_i,
  input  logic         z_i,
  output logic         x_o,
  output logic         c_o,
  output logic         z_o,
  output logic         n_o,
  output logic         v_o
);
  always_comb begin
    x_o = carry_i;
    c_o = carry_i;
    z_o = z_i & ~(|res_i);
    n_o = 1'b0;
    v_o = 1'b0;
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
#(
  parameter  int unsigned NUM_DIGITS = 2,
  localparam int unsigned W          = 4 * NUM_DIGITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [W-1:0]      dst_i,
  input  logic [W-1:0]      src_i,
  input  logic              x_i,
  input  logic              z_i,
  output logic [W-1:0]      result_o,
  output logic              x_o,
  output logic              c_o,
  output logic              z_o,
  output logic              n_o,
  output logic              v_o,
  output logic [FLAG_W-1:0] flag_valid_o,
  output logic              done_o
);
  logic [W-1:0]        opa, opb, sum;
  logic                is_sub, is_neg;
  logic [NUM_DIGITS:0] carry;
  logic                nx_x, nx_c, nx_z, nx_n, nx_v;

  always_comb begin
    is_neg = op_i[1];
    is_sub = (bcd_op_e'(op_i) != OP_ADD);
    opa    = is_neg ? '0 : dst_i;
    opb    = is_neg ? dst_i : src_i;
  end

  assign carry[0] = x_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    bcd_digit u_dig (
      .sub_i (is_sub),
      .a_i   (opa[4*g +: 4]),
      .b_i   (opb[4*g +: 4]),
      .cin_i (carry[g]),
      .dig_o (sum[4*g +: 4]),
      .cout_o(carry[g+1])
    );
  end

  bcd_flags #(.W(W)) u_flags (
    .res_i  (sum),
    .carry_i(carry[NUM_DIGITS]),
    .z_i    (z_i),
    .x_o    (nx_x),
    .c_o    (nx_c),
    .z_o    (nx_z),
    .n_o    (nx_n),
    .v_o    (nx_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      x_o      <= 1'b0;
      c_o      <= 1'b0;
      z_o      <= 1'b0;
      n_o      <= 1'b0;
      v_o      <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        result_o <= sum;
        x_o      <= nx_x;
        c_o      <= nx_c;
        z_o      <= nx_z;
        n_o      <= nx_n;
        v_o      <= nx_v;
      end
    end
  end

  assign flag_valid_o = FLAG_VALID;
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         z_i,
  input logic [W-1:0] result_o,
  input logic         x_o,
  input logic         c_o,
  input logic         z_o,
  input logic         done_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  // R7
  done_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> (done_o == $past(start_i)));

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && !$past(start_i)) |-> ($stable(result_o) && $stable(z_o) && $stable(c_o)));

  // R4
  x_equals_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (x_o == c_o));

  // R5
  z_never_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(start_i) && !$past(z_i)) |-> !z_o);

  // R5
  z_clear_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(start_i) && (result_o != '0)) |-> !z_o);
endmodule

bind bcd_addsub bcd_addsub_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .z_i     (z_i),
  .result_o(result_o),
  .x_o     (x_o),
  .c_o     (c_o),
  .z_o     (z_o),
  .done_o  (done_o)
);

// File: tb/bcd_addsub_bench.sv
module bcd_addsub_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] dst = '0, src = '0;
  logic       x_in = 1'b0, z_in = 1'b0;
  logic [7:0] result;
  logic       x_o, c_o, z_o, n_o, v_o, done;
  logic [4:0] fvalid;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  typedef struct packed {
    logic [7:0] res;
    logic       cy;
    logic       z;
    logic [3:0] req;
  } exp_t;
  exp_t q[$];
  exp_t last;

  always #5 clk = ~clk;

  bcd_addsub u_bcd_addsub (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .op_i(op),
    .dst_i(dst), .src_i(src), .x_i(x_in), .z_i(z_in),
    .result_o(result), .x_o(x_o), .c_o(c_o), .z_o(z_o),
    .n_o(n_o), .v_o(v_o), .flag_valid_o(fvalid), .done_o(done)
  );

  function automatic logic [7:0] to_bcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(logic [1:0] o, int dv, int sv, logic xi, logic zi);
    exp_t e;
    int v;
    @(negedge clk);
    op = o; dst = to_bcd(dv); src = to_bcd(sv); x_in = xi; z_in = zi;
    start = 1'b1;
    if (o == 2'b00) begin
      v = dv + sv + int'(xi); e.cy = (v >= 100); v = v % 100; e.req = 1;
    end else begin
      if (o == 2'b01) begin v = dv - sv - int'(xi); e.req = 2; end
      else begin v = 0 - dv - int'(xi); e.req = 3; end
      e.cy = (v < 0);
      if (v < 0) v += 100;
    end
    e.res = to_bcd(v);
    e.z   = zi && (v == 0);
    q.push_back(e);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (done) begin
          if (q.size() == 0) begin
            chk(1'b0, "R7", "done without start", 1, 0);
          end else begin
            exp_t e;
            string rq;
            e = q.pop_front();
            rq = (e.req == 1) ? "R1" : (e.req == 2) ? "R2" : "R3";
            chk(result == e.res, rq, "result", result, e.res);
            chk(c_o == e.cy && x_o == e.cy, "R4", "x/c", {x_o, c_o}, {e.cy, e.cy});
            chk(z_o == e.z, "R5", "z", z_o, e.z);
            chk(n_o == 1'b0 && v_o == 1'b0 && fvalid == 5'b10101, "R6", "n/v/mask",
                {n_o, v_o, fvalid}, 7'b0010101);
            last = e;
          end
        end else begin
          chk(result == last.res && c_o == last.cy && z_o == last.z, "R8", "hold",
              {result, c_o, z_o}, {last.res, last.cy, last.z});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9
    chk(result == 8'h00 && x_o == 0 && c_o == 0 && z_o == 0 && done == 0, "R9", "reset",
        {result, x_o, c_o, z_o, done}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    last = '0;
    mon_on = 1'b1;

    // R1 corners
    do_op(2'b00, 99, 99, 1'b1, 1'b1); idle(2);   // 99, carry
    do_op(2'b00, 50, 50, 1'b0, 1'b1); idle(1);   // 00 carry, z kept
    do_op(2'b00, 12, 34, 1'b1, 1'b1); idle(1);   // 47, z cleared
    // R2 corners
    do_op(2'b01, 0, 0, 1'b1, 1'b1); idle(1);     // 99 borrow
    do_op(2'b01, 45, 45, 1'b0, 1'b0); idle(1);   // 00, z stays 0 (R5)
    do_op(2'b01, 45, 45, 1'b0, 1'b1); idle(1);   // 00, z stays 1
    // R3 corners, src ignored
    do_op(2'b10, 0, 77, 1'b0, 1'b1); idle(1);    // 00 no borrow
    do_op(2'b10, 0, 33, 1'b1, 1'b1); idle(1);    // 99 borrow
    do_op(2'b11, 1, 55, 1'b0, 1'b1); idle(3);    // alt code -> 99
    // R7 back-to-back starts
    do_op(2'b00, 19, 1, 1'b0, 1'b1);
    do_op(2'b01, 20, 1, 1'b0, 1'b1);
    do_op(2'b10, 10, 0, 1'b0, 1'b1);
    idle(2);

    // sweep
    for (int a = 0; a < 100; a += 3) begin
      for (int b = 0; b < 100; b += 11) begin
        for (int o = 0; o < 3; o++) begin
          do_op(2'(o), a, b, 1'(a + b), 1'b1);
        end
      end
      idle(1);
    end
    idle(4);
    chk(q.size() == 0, "R7", "pending results", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule